// File: doc/BRIEF.md
# Ethernet Ingress Header Classifier

This block watches a byte-wide receive stream, one byte per accepted beat, with a start-of-frame flag on the first byte. It takes the destination address, the EtherType and the two bytes that follow it from the header, and skips the source address. When the last of those bytes is accepted, it raises a result strobe for one cycle. The result carries a destination class (unicast, multicast or broadcast), a MAC-control flag and one hit bit for each programmable EtherType filter.

The input side is a valid/ready stream. The block never applies back-pressure: `in_ready` is held high, and every beat with `in_valid` high is taken. Cycles with `in_valid` low carry no data and do not advance the parse. A beat is the start of a new frame when `in_sof` is high on that beat. Such a beat always restarts the parse, even if a header is part-way through. The filter values and their enable bits are plain configuration inputs. They are sampled on the cycle the final header byte is accepted.

Top module: `eth_rx_classifier`

## Requirements
- R1: While reset is applied, and after it until a full header has been received, `res_valid` is 0. `in_ready` reads 1 during reset.
- R2: If bit 0 of the first destination-address byte is 0, `res_class` is 0 (unicast).
- R3: If all six destination-address bytes are 0xFF, `res_class` is 2 (broadcast).
- R4: If bit 0 of the first destination-address byte is 1 and any address bit is 0, `res_class` is 1 (multicast).
- R5: `res_mac_ctrl` is 1 when bytes 12..13 of the frame equal 0x8808 and the opcode is not 0x0001. The opcode is the big-endian value of bytes 14..15. In every other case `res_mac_ctrl` is 0.
- R6: `res_type_hit[j]` is 1 exactly when `cfg_type_en[j]` is 1 and `cfg_type_val[16j+15:16j]` equals the EtherType (bytes 12..13, big-endian). A disabled filter never hits.
- R7: `res_valid` is high for exactly one cycle: the cycle after the 16th header byte (byte 15) is accepted. There is one strobe per frame.
- R8: A frame that is followed by a new start-of-frame before 16 bytes have arrived produces no strobe. The new frame is parsed from its first byte.
- R9: Cycles with `in_valid` low do not change the parse. A header spread out by idle cycles gives the same result as one sent back to back.
- R10: `in_ready` is always 1.
- R11: Bytes received after byte 15 and before the next start-of-frame cause no further strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte is valid |
| in_ready | output | 1 | Always high; the block never stalls |
| in_sof | input | 1 | Marks the first byte of a frame |
| in_data | input | 8 | Frame byte |
| cfg_type_en | input | NUM_FILT | Per-filter enable |
| cfg_type_val | input | 16*NUM_FILT | EtherType filter values; filter j at bits 16j+15:16j |
| res_valid | output | 1 | One-cycle result strobe |
| res_class | output | 2 | 0 unicast, 1 multicast, 2 broadcast |
| res_mac_ctrl | output | 1 | MAC control frame, not a pause opcode |
| res_type_hit | output | NUM_FILT | Per-filter EtherType match |

## Verification
The first address byte is swept through all 256 values while the other five bytes are 0xFF. This separates the broadcast case from the multicast case and from the unicast case. Next, a single bit is cleared in each later address byte in turn. This shows that broadcast needs every bit set, and that only bit 0 of the first byte sets the group class. EtherTypes that are equal to, or one bit away from, 0x8808 are paired with opcodes near 0x0001, to check both parts of the MAC-control rule. Every filter enable mask is tried against each filter value. The bench also sends idle gaps, truncated frames and trailing payload bytes, to check that the strobe appears only once per full header.

// File: rtl/eth_cls_pkg.sv
package eth_cls_pkg;

  typedef enum logic [1:0] {
    DST_UCAST = 2'd0,
    DST_MCAST = 2'd1,
    DST_BCAST = 2'd2
  } dst_class_e;

  localparam int unsigned DA_BYTES   = 6;
  localparam int unsigned ETYPE_POS  = 12;
  localparam int unsigned OPC_POS    = 14;
  localparam int unsigned HDR_BYTES  = 16;
  localparam int unsigned ETYPE_W    = 16;

  localparam logic [15:0] MAC_CTRL_ETYPE = 16'h8808;
  localparam logic [15:0] PAUSE_OPCODE   = 16'h0001;

endpackage

// File: rtl/eth_cls_hdr_ctr.sv
module eth_cls_hdr_ctr #(
  parameter int unsigned HDR_LEN = 16,
  parameter int unsigned CW      = $clog2(HDR_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_sof,
  output logic [CW-1:0] byte_idx,
  output logic          byte_take,
  output logic          last_byte
);

  localparam logic [CW-1:0] IDLE_CNT = CW'(HDR_LEN);
  localparam logic [CW-1:0] LAST_IDX = CW'(HDR_LEN - 1);

  logic [CW-1:0] cnt_q;

  always_comb begin
    byte_idx  = in_sof ? '0 : cnt_q;
    byte_take = in_valid && (in_sof || (cnt_q < IDLE_CNT));
    last_byte = byte_take && (byte_idx == LAST_IDX);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= IDLE_CNT;
    end else if (byte_take) begin
      cnt_q <= byte_idx + CW'(1);
    end
  end

  assert_sof_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof) |=> (cnt_q == CW'(1)));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(cnt_q));

endmodule

// File: rtl/eth_cls_da_chk.sv
module eth_cls_da_chk #(
  parameter int unsigned DA_LEN = 6,
  parameter int unsigned CW     = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [CW-1:0] idx,
  input  logic [7:0]    data,
  output logic          ig_bit,
  output logic          all_ones
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ig_bit   <= 1'b0;
      all_ones <= 1'b0;
    end else if (take && (idx == '0)) begin
      ig_bit   <= data[0];
      all_ones <= &data;
    end else if (take && (idx < CW'(DA_LEN))) begin
      all_ones <= all_ones & (&data);
    end
  end

  assert_ig_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (idx == '0)) |=> (ig_bit == $past(data[0])));

  assert_ones_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (idx < CW'(DA_LEN)) && !(&data)) |=> !all_ones);

endmodule

// File: rtl/eth_cls_type_match.sv
module eth_cls_type_match #(
  parameter int unsigned NF = 4,
  parameter int unsigned TW = 16
) (
  input  logic [TW-1:0]    etype,
  input  logic [NF-1:0]    en,
  input  logic [NF*TW-1:0] vals,
  output logic [NF-1:0]    hit
);

  for (genvar g = 0; g < NF; g++) begin : g_filt
    assign hit[g] = en[g] && (vals[g*TW +: TW] == etype);
  end

endmodule

// File: rtl/eth_rx_classifier.sv
module eth_rx_classifier
  import eth_cls_pkg::*;
#(
  parameter int unsigned NUM_FILT = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic                       in_sof,
  input  logic [7:0]                 in_data,
  input  logic [NUM_FILT-1:0]        cfg_type_en,
  input  logic [NUM_FILT*ETYPE_W-1:0] cfg_type_val,
  output logic                       res_valid,
  output logic [1:0]                 res_class,
  output logic                       res_mac_ctrl,
  output logic [NUM_FILT-1:0]        res_type_hit
);

  localparam int unsigned CW = $clog2(HDR_BYTES + 1);

  logic [CW-1:0]       byte_idx;
  logic                byte_take;
  logic                last_byte;
  logic                ig_bit;
  logic                all_ones;
  logic [ETYPE_W-1:0]  etype_q;
  logic [7:0]          opc_hi_q;
  logic [NUM_FILT-1:0] hit_c;
  logic [15:0]         opcode_c;
  logic                mac_c;
  dst_class_e          cls_c;

  assign in_ready = 1'b1;

  eth_cls_hdr_ctr #(.HDR_LEN(HDR_BYTES), .CW(CW)) ctr_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .byte_idx(byte_idx), .byte_take(byte_take), .last_byte(last_byte)
  );

  eth_cls_da_chk #(.DA_LEN(DA_BYTES), .CW(CW)) da_i (
    .clk(clk), .rst_n(rst_n), .take(byte_take), .idx(byte_idx),
    .data(in_data), .ig_bit(ig_bit), .all_ones(all_ones)
  );

  eth_cls_type_match #(.NF(NUM_FILT), .TW(ETYPE_W)) tm_i (
    .etype(etype_q), .en(cfg_type_en), .vals(cfg_type_val), .hit(hit_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      etype_q  <= '0;
      opc_hi_q <= '0;
    end else if (byte_take) begin
      if (byte_idx == CW'(ETYPE_POS))     etype_q[15:8] <= in_data;
      if (byte_idx == CW'(ETYPE_POS + 1)) etype_q[7:0]  <= in_data;
      if (byte_idx == CW'(OPC_POS))       opc_hi_q      <= in_data;
    end
  end

  always_comb begin
    opcode_c = {opc_hi_q, in_data};
    mac_c    = (etype_q == MAC_CTRL_ETYPE) && (opcode_c != PAUSE_OPCODE);
    if (all_ones)    cls_c = DST_BCAST;
    else if (ig_bit) cls_c = DST_MCAST;
    else             cls_c = DST_UCAST;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid    <= 1'b0;
      res_class    <= 2'd0;
      res_mac_ctrl <= 1'b0;
      res_type_hit <= '0;
    end else begin
      res_valid <= last_byte;
      if (last_byte) begin
        res_class    <= cls_c;
        res_mac_ctrl <= mac_c;
        res_type_hit <= hit_c;
      end
    end
  end

  assert_single_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  assert_strobe_follows_beat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(in_valid));

  assert_legal_class_R3: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_class != 2'd3));

  assert_hit_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ((res_type_hit & ~$past(cfg_type_en)) == '0));

endmodule

// File: tb/eth_rx_classifier_tb_top.sv
module eth_rx_classifier_tb_top;
  localparam int NF = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic            rst_n, in_valid, in_sof, in_ready;
  logic [7:0]      in_data;
  logic [NF-1:0]   cfg_en;
  logic [NF*16-1:0] cfg_val;
  logic            res_valid, res_mac_ctrl;
  logic [1:0]      res_class;
  logic [NF-1:0]   res_type_hit;

  eth_rx_classifier #(.NUM_FILT(NF)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sof(in_sof), .in_data(in_data), .cfg_type_en(cfg_en),
    .cfg_type_val(cfg_val), .res_valid(res_valid), .res_class(res_class),
    .res_mac_ctrl(res_mac_ctrl), .res_type_hit(res_type_hit)
  );

  int total = 0, bad = 0, strobes = 0;
  bit done = 1'b0;
  logic [7:0] fb [16];

  always @(negedge clk) if (rst_n === 1'b1 && res_valid === 1'b1) strobes++;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_class(input logic [47:0] da);
    if (da == 48'hFFFF_FFFF_FFFF) return 2'd2;
    if (da[40]) return 2'd1;
    return 2'd0;
  endfunction

  function automatic logic [NF-1:0] exp_hit(input logic [15:0] et);
    logic [NF-1:0] h;
    for (int j = 0; j < NF; j++) h[j] = cfg_en[j] && (cfg_val[16*j +: 16] == et);
    return h;
  endfunction

  task automatic build(input logic [47:0] da, input logic [15:0] et, input logic [15:0] op);
    for (int i = 0; i < 6; i++) fb[i] = da[47-8*i -: 8];
    for (int i = 0; i < 6; i++) fb[6+i] = 8'h30 + 8'(i);
    fb[12] = et[15:8]; fb[13] = et[7:0];
    fb[14] = op[15:8]; fb[15] = op[7:0];
  endtask

  task automatic send(input int n, input bit gaps, input bit sof);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sof = sof && (i == 0); in_data = fb[i];
      if (gaps && (i % 3 == 1)) begin
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_data = 8'hFF;
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0;
  endtask

  task automatic frame_check(input logic [47:0] da, input logic [15:0] et,
                             input logic [15:0] op, input bit gaps);
    int s0;
    logic [1:0] ec;
    string ctag;
    s0 = strobes;
    ec = exp_class(da);
    ctag = (ec == 2'd2) ? "R3" : (ec == 2'd1) ? "R4" : "R2";
    build(da, et, op);
    send(16, gaps, 1'b1);
    chk(res_valid === 1'b1, "R7 strobe", 64'(res_valid), 64'd1);
    chk(res_class === ec, ctag, 64'(res_class), 64'(ec));
    chk(res_mac_ctrl === ((et == 16'h8808) && (op != 16'h0001)), "R5",
        64'(res_mac_ctrl), 64'((et == 16'h8808) && (op != 16'h0001)));
    chk(res_type_hit === exp_hit(et), "R6", 64'(res_type_hit), 64'(exp_hit(et)));
    @(negedge clk); #1;
    chk(res_valid === 1'b0, "R7 one cycle", 64'(res_valid), 64'd0);
    chk(strobes == s0 + 1, gaps ? "R9 strobe count" : "R7 strobe count",
        64'(strobes - s0), 64'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int s0;
    logic [47:0] da;
    rst_n = 1'b0; in_valid = 1'b0; in_sof = 1'b0; in_data = 8'h00;
    cfg_en = '0;
    cfg_val = {16'h8808, 16'h88CC, 16'h86DD, 16'h0800};
    repeat (4) @(negedge clk);
    chk(res_valid === 1'b0, "R1 reset strobe", 64'(res_valid), 64'd0);
    chk(in_ready === 1'b1, "R10 ready in reset", 64'(in_ready), 64'd1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(res_valid === 1'b0 && strobes == 0, "R1 idle after reset", 64'(strobes), 64'd0);

    // R2 R3 R4: sweep first address byte, rest all ones
    for (int b = 0; b < 256; b++)
      frame_check({8'(b), 40'hFF_FFFF_FFFF}, 16'h1234, 16'h0000, b[0] ^ b[3]);
    // R4: one bit cleared in a later byte
    for (int k = 1; k < 6; k++)
      for (int p = 0; p < 8; p++) begin
        da = 48'hFFFF_FFFF_FFFF;
        da[47 - 8*k - (7 - p)] = 1'b0;
        frame_check(da, 16'h4321, 16'h0000, 1'b0);
      end
    // R2: unicast with group bit clear elsewhere
    frame_check(48'hFE00_0000_0001, 16'h0000, 16'h0000, 1'b0);

    // R5: EtherType and opcode near the control values
    for (int e = 0; e < 4; e++)
      for (int o = 0; o < 6; o++) begin
        logic [15:0] ets [4];
        logic [15:0] ops [6];
        ets = '{16'h8808, 16'h8809, 16'h0808, 16'h8008};
        ops = '{16'h0000, 16'h0001, 16'h0101, 16'h0100, 16'h8001, 16'hFFFF};
        frame_check(48'h0200_0000_0000, ets[e], ops[o], o[0]);
      end

    // R6: every enable mask against each filter value and a miss
    for (int m = 0; m < 16; m++) begin
      cfg_en = 4'(m);
      for (int j = 0; j < NF; j++)
        frame_check(48'h0011_2233_4455, cfg_val[16*j +: 16], 16'h0001, 1'b0);
      frame_check(48'h0011_2233_4455, 16'h9999, 16'h0001, 1'b0);
    end
    cfg_val[31:16] = 16'h0800;
    cfg_en = 4'b0011;
    frame_check(48'h0011_2233_4455, 16'h0800, 16'h0000, 1'b0);

    // R8: truncated frames then a full one
    s0 = strobes;
    build(48'hFFFF_FFFF_FFFF, 16'h8808, 16'h0000);
    send(10, 1'b0, 1'b1);
    send(15, 1'b1, 1'b1);
    @(negedge clk); #1;
    chk(strobes == s0, "R8 truncated", 64'(strobes - s0), 64'd0);
    frame_check(48'h0100_5E00_0001, 16'h86DD, 16'h0000, 1'b0);

    // R11: trailing payload bytes without a new start
    s0 = strobes;
    build(48'h0000_0000_0000, 16'h8808, 16'h0000);
    send(16, 1'b0, 1'b0);
    send(16, 1'b0, 1'b0);
    @(negedge clk); #1;
    chk(strobes == s0, "R11 trailing bytes", 64'(strobes - s0), 64'd0);
    chk(in_ready === 1'b1, "R10 ready", 64'(in_ready), 64'd1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule